// File: doc/BRIEF.md
# Debug Mode Unlock Gate

This block decides when a small pin-limited chip hands its pins to a JTAG test access port. The chip has 8 dedicated inputs, 8 bidirectional inputs and 8 outputs. Unlocking takes two steps. First, the debug-arm bit must be set on the dedicated inputs in the first cycle of a streaming transaction. Second, while the block is armed, the full 16-bit input word must show a fixed unlock value on a falling clock edge. When both steps succeed, a sticky mode flag is raised.

While the flag is up, the dedicated inputs are steered to the TAP and the outputs are driven from the TAP. The bidirectional inputs are left alone. The main sequencer can be told to pause through a configuration input. The flag falls only on hard reset or on an exit pulse. The exit pulse may come from another clock domain, so it is resynchronised before it acts. The TAP controller and the datapath lie outside this block.

Top module: `debug_knock_unlock`

## Requirements
- R1: While `rst_n` is low, `jtag_mode` and `fsm_pause` are 0, `uo_out` equals `core_uo`, `ui_core` equals `ui_in`, and `ui_tap` is 0.
- R2: In a cycle where `txn_start` is 1, bit 6 of `ui_in` decides the arm state. That decision applies already at the falling edge of the same cycle and holds until the next `txn_start`.
- R3: When the block is armed, a falling edge that sees `{uio_in, ui_in}` == 16'hACDC (that is, `uio_in` = 8'hAC and `ui_in` = 8'hDC) sets `jtag_mode`. The change is visible right after that edge.
- R4: A 16-bit word that differs from 16'hACDC in any bit leaves `jtag_mode` unchanged, even when the block is armed.
- R5: When the arm decision of the current transaction is 0, the unlock word is ignored for the whole transaction. A later `txn_start` with bit 6 set re-arms the block.
- R6: Once set, `jtag_mode` stays 1 through later transaction starts that are not armed and through any input word, until an exit event or a reset.
- R7: A one-cycle high pulse on `exit_req`, driven in cycle k, clears `jtag_mode` at the falling edge of cycle k+2. At that edge the exit wins over a coinciding unlock word.
- R8: `fsm_pause` equals `jtag_mode` AND `pause_cfg`.
- R9: When `jtag_mode` is 1: `ui_tap` = `ui_in`, `ui_core` = 0, and `uo_out` = `tap_uo`. When `jtag_mode` is 0: `ui_tap` = 0, `ui_core` = `ui_in`, and `uo_out` = `core_uo`.
- R10: Driving `rst_n` low clears `jtag_mode` at once, without waiting for a clock edge, and clears the arm state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the unlock word is compared on its falling edge |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| txn_start | input | 1 | High in the first cycle of a streaming transaction |
| ui_in | input | 8 | Dedicated inputs; bit 6 is the arm bit |
| uio_in | input | 8 | Bidirectional inputs; upper byte of the unlock word |
| exit_req | input | 1 | Exit pulse, possibly asynchronous |
| pause_cfg | input | 1 | Asks for the sequencer to pause while in debug mode |
| core_uo | input | 8 | Output byte from the normal datapath |
| tap_uo | input | 8 | Output byte from the TAP (TDO and probes) |
| jtag_mode | output | 1 | Sticky debug mode flag; pin mux select |
| fsm_pause | output | 1 | Pause request for the main sequencer |
| ui_core | output | 8 | Dedicated inputs as seen by the datapath |
| ui_tap | output | 8 | Dedicated inputs as seen by the TAP |
| uo_out | output | 8 | Muxed output pins |

## Verification
A wrong arm state or a wrong match shows at the ports one half-cycle later, at the falling edge that should or should not have raised `jtag_mode`. The output mux flips in the same moment, so `uo_out` shows the wrong source right away. A broken exit path shows two rising edges after the pulse: the flag survives when it should drop, or it drops a cycle early or late. The stimulus therefore walks arm, disarm, near-miss words, same-cycle arming, and an exit that collides with an unlock word, and it checks every port in each cycle right after the falling edge.

// File: rtl/dku_pkg.sv
package dku_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  // Unlock comparison kept as a function so the rule lives in one place.
  function automatic logic knock_match(input logic [WORD_W-1:0] word,
                                       input logic [WORD_W-1:0] key);
    return (word ^ key) == '0;
  endfunction

  // Mode flag next-state: exit dominates, then a valid knock sets, else hold.
  function automatic logic mode_next(input logic cur, input logic hit,
                                     input logic leave);
    if (leave) return 1'b0;
    if (hit)   return 1'b1;
    return cur;
  endfunction
endpackage

// File: rtl/dku_arm_latch.sv
module dku_arm_latch #(
  parameter int DATA_W  = 8,
  parameter int ARM_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic [DATA_W-1:0] ui_in,
  output logic              arm_eff
);
  logic armed_q;
  logic arm_now;

  assign arm_now = ui_in[ARM_BIT];
  // The cycle that starts a transaction already uses its own arm bit.
  assign arm_eff = txn_start ? arm_now : armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed_q <= 1'b0;
    else if (txn_start) armed_q <= arm_now;
  end

  AST_ARM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |=> armed_q == $past(ui_in[ARM_BIT])) else $error("arm capture"); // R2
  AST_ARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_start |=> $stable(armed_q)) else $error("arm hold"); // R2
endmodule

// File: rtl/dku_exit_sync.sv
module dku_exit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic exit_req,
  output logic exit_evt
);
  localparam int LAST = STAGES - 1;
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= exit_req;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];
  end

  assign exit_evt = sync_q[LAST] & ~prev_q;

  AST_EXIT_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt |=> !exit_evt) else $error("exit not one-shot"); // R7
endmodule

// File: rtl/dku_knock_match.sv
module dku_knock_match
  import dku_pkg::*;
#(
  parameter logic [WORD_W-1:0] KEY = 16'hACDC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_eff,
  input  logic              exit_evt,
  input  logic [WORD_W-1:0] word,
  output logic              mode_q
);
  logic knock_hit;

  assign knock_hit = arm_eff & knock_match(word, KEY);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_next(mode_q, knock_hit, exit_evt);
  end

  AST_KNOCK_SETS: assert property (@(negedge clk) disable iff (!rst_n)
    (knock_hit && !exit_evt) |=> mode_q) else $error("knock missed"); // R3
  AST_EXIT_CLEARS: assert property (@(negedge clk) disable iff (!rst_n)
    exit_evt |=> !mode_q) else $error("exit missed"); // R7
  AST_MODE_STICKY: assert property (@(negedge clk) disable iff (!rst_n)
    (mode_q && !exit_evt) |=> mode_q) else $error("mode dropped"); // R6
  AST_NO_SET_UNARMED: assert property (@(negedge clk) disable iff (!rst_n)
    (!arm_eff && !mode_q) |=> !mode_q) else $error("unarmed set"); // R5
endmodule

// File: rtl/debug_knock_unlock.sv
module debug_knock_unlock
  import dku_pkg::*;
#(
  parameter int                DATA_W      = BYTE_W,
  parameter int                ARM_BIT     = 6,
  parameter int                SYNC_STAGES = 2,
  parameter logic [2*DATA_W-1:0] UNLOCK_KEY = 16'hACDC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic [DATA_W-1:0] ui_in,
  input  logic [DATA_W-1:0] uio_in,
  input  logic              exit_req,
  input  logic              pause_cfg,
  input  logic [DATA_W-1:0] core_uo,
  input  logic [DATA_W-1:0] tap_uo,
  output logic              jtag_mode,
  output logic              fsm_pause,
  output logic [DATA_W-1:0] ui_core,
  output logic [DATA_W-1:0] ui_tap,
  output logic [DATA_W-1:0] uo_out
);
  logic arm_eff;
  logic exit_evt;
  logic mode_q;

  dku_arm_latch #(.DATA_W(DATA_W), .ARM_BIT(ARM_BIT)) u_arm (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .ui_in(ui_in),
    .arm_eff(arm_eff));

  dku_exit_sync #(.STAGES(SYNC_STAGES)) u_exit (
    .clk(clk), .rst_n(rst_n), .exit_req(exit_req), .exit_evt(exit_evt));

  dku_knock_match #(.KEY(UNLOCK_KEY)) u_knock (
    .clk(clk), .rst_n(rst_n), .arm_eff(arm_eff), .exit_evt(exit_evt),
    .word({uio_in, ui_in}), .mode_q(mode_q));

  assign jtag_mode = mode_q;
  assign fsm_pause = mode_q & pause_cfg;
  assign ui_core   = mode_q ? '0 : ui_in;
  assign ui_tap    = mode_q ? ui_in : '0;
  assign uo_out    = mode_q ? tap_uo : core_uo;

  AST_PINS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ui_core & ui_tap) == '0) else $error("pin overlap"); // R9
endmodule

// File: tb/sim_debug_knock_unlock.sv
module sim_debug_knock_unlock;
  localparam int PERIOD = 10;
  localparam logic [7:0] CORE_V = 8'h3C;
  localparam logic [7:0] TAP_V  = 8'hA5;
  localparam int NROWS = 17;
  // {txn_start, ui_in, uio_in, exit_req, pause_cfg, expected jtag_mode}
  localparam logic [19:0] TBL [NROWS] = '{
    {1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},  // R5 unarmed start
    {1'b0, 8'hDC, 8'hAC, 1'b0, 1'b0, 1'b0},  // R5 knock ignored
    {1'b0, 8'hDC, 8'hAC, 1'b0, 1'b1, 1'b0},  // R5 R8
    {1'b1, 8'h40, 8'h00, 1'b0, 1'b0, 1'b0},  // R2 arm
    {1'b0, 8'hDD, 8'hAC, 1'b0, 1'b0, 1'b0},  // R4 low byte off
    {1'b0, 8'hDC, 8'hAD, 1'b0, 1'b0, 1'b0},  // R4 high byte off
    {1'b0, 8'hDC, 8'hAC, 1'b0, 1'b1, 1'b1},  // R3 R8
    {1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1},  // R6 sticky, disarms
    {1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1},  // R7 exit pulse
    {1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1},  // R7 still set
    {1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0},  // R7 cleared
    {1'b0, 8'hDC, 8'hAC, 1'b0, 1'b0, 1'b0},  // R5 disarmed
    {1'b1, 8'hDC, 8'hAC, 1'b0, 1'b0, 1'b1},  // R2 same-cycle arm
    {1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1},  // R7 exit pulse
    {1'b0, 8'hDC, 8'hAC, 1'b0, 1'b0, 1'b1},  // R6
    {1'b0, 8'hDC, 8'hAC, 1'b0, 1'b0, 1'b0},  // R7 exit beats knock
    {1'b0, 8'hDC, 8'hAC, 1'b0, 1'b0, 1'b1}   // R3 re-knock
  };

  logic clk = 1'b0, rst_n = 1'b0, txn_start = 1'b0, exit_req = 1'b0, pause_cfg = 1'b0;
  logic [7:0] ui_in = '0, uio_in = '0;
  logic jtag_mode, fsm_pause;
  logic [7:0] ui_core, ui_tap, uo_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  debug_knock_unlock u0 (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .ui_in(ui_in), .uio_in(uio_in),
    .exit_req(exit_req), .pause_cfg(pause_cfg), .core_uo(CORE_V), .tap_uo(TAP_V),
    .jtag_mode(jtag_mode), .fsm_pause(fsm_pause), .ui_core(ui_core), .ui_tap(ui_tap),
    .uo_out(uo_out));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic m, input logic p);
    chk({req, " mode"}, {7'd0, jtag_mode}, {7'd0, m});
    chk("R8 pause", {7'd0, fsm_pause}, {7'd0, m & p});
    chk("R9 uo_out", uo_out, m ? TAP_V : CORE_V);
    chk("R9 ui_core", ui_core, m ? 8'h00 : ui_in);
    chk("R9 ui_tap", ui_tap, m ? ui_in : 8'h00);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk_all("R1 reset", 1'b0, 1'b0);
    pause_cfg = 1'b1; ui_in = 8'hDC; uio_in = 8'hAC;
    #1;
    chk_all("R1 reset inputs", 1'b0, 1'b1);
    pause_cfg = 1'b0; ui_in = '0; uio_in = '0;
    rst_n = 1'b1;
    for (int i = 0; i < NROWS; i++) begin
      @(posedge clk);
      #1;
      {txn_start, ui_in, uio_in, exit_req, pause_cfg} = TBL[i][19:1];
      #6;
      chk_all($sformatf("row %0d", i), TBL[i][0], pause_cfg);
    end
    // R10: asynchronous reset mid-cycle with the mode set
    @(posedge clk);
    #1;
    {txn_start, ui_in, uio_in, exit_req, pause_cfg} = '0;
    #2;
    chk("R10 mode before reset", {7'd0, jtag_mode}, 8'h01);
    rst_n = 1'b0;
    #1;
    chk("R10 async clear", {7'd0, jtag_mode}, 8'h00);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R10: arm state also cleared, so a knock without a new start is ignored
    @(posedge clk);
    #1;
    ui_in = 8'hDC; uio_in = 8'hAC;
    #6;
    chk("R10 arm cleared", {7'd0, jtag_mode}, 8'h00);
    // R2: start with arm bit in a cycle without the key, knock next cycle
    @(posedge clk);
    #1;
    txn_start = 1'b1; ui_in = 8'h40; uio_in = 8'h00;
    @(posedge clk);
    #1;
    txn_start = 1'b0; ui_in = 8'hDC; uio_in = 8'hAC;
    #6;
    chk("R2 armed after start", {7'd0, jtag_mode}, 8'h01);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule